// File: doc/BRIEF.md
# Octal DAC Register Bank Controller

This block is the digital register core of an eight-channel, 12-bit voltage-output converter. A host issues one command per clock on a small parallel port: a valid strobe, a 4-bit operation code, a 4-bit channel address and a 12-bit data word. Each channel keeps two codes. The staged (input) code takes new values. The live (active) code drives the converter. Several command paths move values between the two registers. A per-channel mask decides whether a channel obeys the external latch pin.

Two pins act on the channels directly. An active-low latch pin moves the staged code into the live code for every unmasked channel. An active-low clear pin, once synchronised, forces a selectable clear value into every channel on its falling edge. The block also holds a 2-bit power-down mode per channel and an on-chip reference enable. It exports every live code, the power modes, a per-channel output enable and the configuration state.

Top module: `dacbank_ctrl`

## Requirements
- R1: After a synchronous reset, every staged and live code is 0, or 0x800 when `MID_RESET` is 1. All power modes are 0 and all output enables are 1. The reference enable is 0, all latch masks are 0 and the clear selector is 0.
- R2: Operation 0 (stage) writes the data word into the staged code of the addressed channel. The live code is unchanged, and no register changes in the same edge unless the latch pin or the clear pin acts on it.
- R3: Operation 1 (commit) copies the staged code of the addressed channel into its live code on the edge that samples the command. Other channels are unaffected.
- R4: For operations 0 to 2, address 15 selects every channel. Addresses 8 to 14 select no channel.
- R5: Operation 2 (stage and commit) writes the data word into both the staged code and the live code of the addressed channel in one edge.
- R6: Operation 3 writes the data word into both codes of the addressed channel. In the same edge, every other channel copies its staged code into its live code.
- R7: Operation 4 sets the power mode of the addressed channel (0 to 7) to data bits [1:0]. The modes are 0 normal, 1 1 kΩ to ground, 2 100 kΩ to ground and 3 high impedance. The output enable is 1 only in mode 0. The codes are kept in every mode.
- R8: Operation 5 sets the reference enable to data bit 0. No other input changes it.
- R9: Operation 6 sets the latch mask of the addressed channel to data bit 0. On each edge that samples `ldac_n_i` low, every channel with mask 0 copies its staged code (the value before that edge) into its live code. Masked channels keep their live code. A commit or write from a command in the same edge takes precedence.
- R10: Operation 7 sets the clear selector to data bits [1:0]. The values are 0 zero (0x000), 1 midscale (0x800), 2 full scale (0xFFF) and 3 no action. A high-to-low change of `clr_n_i` is synchronised by two flip-flops. If `clr_n_i` is first sampled low at edge k, both codes of every channel take the clear value at edge k+2. Selector 3 leaves all codes unchanged.
- R11: When a clear applies, it takes precedence over any code command and over the latch pin in that edge. Non-code commands still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Operation code (0 to 7 used) |
| cmd_addr_i | input | 4 | Channel address, 15 selects all |
| cmd_data_i | input | 12 | Data word |
| ldac_n_i | input | 1 | Active-low latch pin, level sampled |
| clr_n_i | input | 1 | Active-low asynchronous clear pin |
| code_o | output | 96 | Live codes, channel i at bits [12i+11:12i] |
| pmode_o | output | 16 | Power modes, channel i at bits [2i+1:2i] |
| out_en_o | output | 8 | Output enable per channel |
| ref_en_o | output | 1 | On-chip reference enable |
| ldac_mask_o | output | 8 | Latch mask per channel |
| clr_code_o | output | 2 | Clear selector |

## Verification
The bench builds the main instance with the default eight channels, 12-bit codes and `MID_RESET` at 0. Full scale (0xFFF), the broadcast address 15 and the unused addresses 8 to 14 are therefore all reachable. A second instance with `MID_RESET` at 1 sits beside it, so the midscale power-up code is checked as well. A reference model in the bench follows the clear pin through its two-stage synchroniser. This lets a command be landed on exactly the edge where a clear applies, which exercises the precedence rule.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int          ADDR_W   = 4;
    localparam logic [3:0]  ADDR_ALL = 4'hF;

    typedef enum logic [3:0] {
        OP_STAGE      = 4'd0,
        OP_COMMIT     = 4'd1,
        OP_STAGE_COMM = 4'd2,
        OP_STAGE_ALL  = 4'd3,
        OP_PMODE      = 4'd4,
        OP_REF        = 4'd5,
        OP_MASK       = 4'd6,
        OP_CLRSEL     = 4'd7
    } op_e;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_LOAD1K = 2'd1,
        PM_LOAD100K = 2'd2,
        PM_HIZ    = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        CS_ZERO = 2'd0,
        CS_MID  = 2'd1,
        CS_FULL = 2'd2,
        CS_NONE = 2'd3
    } clrsel_e;

    // Per-channel strobes produced by the command decoder
    typedef struct packed {
        logic stage_wr;   // write data into staged code
        logic live_wr;    // write data into live code
        logic live_copy;  // copy staged code into live code
        logic pm_wr;      // write power mode
        logic mask_wr;    // write latch mask
    } ch_ctl_t;

    function automatic logic is_powered(input logic [1:0] pm);
        return pm == PM_NORMAL;
    endfunction

endpackage

// File: rtl/dacbank_cmd_dec.sv
module dacbank_cmd_dec
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                       valid_i,
    input  logic [3:0]                 op_i,
    input  logic [ADDR_W-1:0]          addr_i,
    output ch_ctl_t [NUM_CH-1:0]       ctl_o,
    output logic                       ref_wr_o,
    output logic                       clrsel_wr_o
);

    op_e op;
    assign op = op_e'(op_i);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic sel_one;
        logic sel_grp;
        assign sel_one = valid_i && (addr_i == ADDR_W'(g));
        assign sel_grp = sel_one || (valid_i && (addr_i == ADDR_ALL));

        always_comb begin
            ctl_o[g] = '0;
            case (op)
                OP_STAGE:      ctl_o[g].stage_wr = sel_grp;
                OP_COMMIT:     ctl_o[g].live_copy = sel_grp;
                OP_STAGE_COMM: begin
                    ctl_o[g].stage_wr = sel_grp;
                    ctl_o[g].live_wr  = sel_grp;
                end
                OP_STAGE_ALL:  begin
                    ctl_o[g].stage_wr  = sel_grp;
                    ctl_o[g].live_wr   = sel_grp;
                    ctl_o[g].live_copy = valid_i && !sel_grp;
                end
                OP_PMODE:      ctl_o[g].pm_wr = sel_one;
                OP_MASK:       ctl_o[g].mask_wr = sel_one;
                default:       ctl_o[g] = '0;
            endcase
        end
    end

    assign ref_wr_o    = valid_i && (op == OP_REF);
    assign clrsel_wr_o = valid_i && (op == OP_CLRSEL);

endmodule

// File: rtl/dacbank_clr_sync.sv
module dacbank_clr_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic fall_o
);

    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            hist_q <= 1'b1;
        end else begin
            meta_q <= pin_n_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign fall_o = hist_q && !sync_q;

    // R10
    clr_fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/dacbank_channel.sv
module dacbank_channel
    import dacbank_pkg::*;
#(
    parameter int               CODE_W     = 12,
    parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_ctl_t           ctl_i,
    input  logic [CODE_W-1:0] data_i,
    input  logic [1:0]        pm_i,
    input  logic              mask_i,
    input  logic              ldac_low_i,
    input  logic              clr_apply_i,
    input  logic [CODE_W-1:0] clr_val_i,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        pmode_o,
    output logic              out_en_o,
    output logic              mask_o
);

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] live_q;
    logic [1:0]        pm_q;
    logic              mask_q;
    logic              latch_take;

    assign latch_take = ldac_low_i && !mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RESET_CODE;
            live_q  <= RESET_CODE;
        end else if (clr_apply_i) begin
            stage_q <= clr_val_i;
            live_q  <= clr_val_i;
        end else begin
            if (ctl_i.stage_wr) begin
                stage_q <= data_i;
            end
            if (ctl_i.live_wr) begin
                live_q <= data_i;
            end else if (ctl_i.live_copy || latch_take) begin
                live_q <= stage_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_q   <= PM_NORMAL;
            mask_q <= 1'b0;
        end else begin
            if (ctl_i.pm_wr) begin
                pm_q <= pm_i;
            end
            if (ctl_i.mask_wr) begin
                mask_q <= mask_i;
            end
        end
    end

    assign code_o   = live_q;
    assign pmode_o  = pm_q;
    assign out_en_o = is_powered(pm_q);
    assign mask_o   = mask_q;

    // R2
    stage_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.stage_wr && !clr_apply_i) |=> (stage_q == $past(data_i)));

    // R2
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.stage_wr && !clr_apply_i) |=> $stable(stage_q));

    // R9
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_q && !ctl_i.live_wr && !ctl_i.live_copy && !clr_apply_i) |=> $stable(live_q));

    // R10
    clear_load_chk: assert property (@(posedge clk) disable iff (rst)
        clr_apply_i |=> (live_q == $past(clr_val_i) && stage_q == $past(clr_val_i)));

    // R7
    pm_keeps_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.pm_wr && !ctl_i.live_wr && !ctl_i.live_copy && !latch_take && !clr_apply_i)
            |=> $stable(live_q));

endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl
    import dacbank_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int CODE_W    = 12,
    parameter bit MID_RESET = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid_i,
    input  logic [3:0]               cmd_op_i,
    input  logic [3:0]               cmd_addr_i,
    input  logic [CODE_W-1:0]        cmd_data_i,
    input  logic                     ldac_n_i,
    input  logic                     clr_n_i,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [2*NUM_CH-1:0]      pmode_o,
    output logic [NUM_CH-1:0]        out_en_o,
    output logic                     ref_en_o,
    output logic [NUM_CH-1:0]        ldac_mask_o,
    output logic [1:0]               clr_code_o
);

    localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] FULL_CODE = '1;
    localparam logic [CODE_W-1:0] RST_CODE  = MID_RESET ? MID_CODE : '0;

    ch_ctl_t [NUM_CH-1:0] ctl;
    logic                 ref_wr;
    logic                 clrsel_wr;
    logic                 clr_fall;
    logic                 clr_apply;
    logic [CODE_W-1:0]    clr_val;
    logic                 ref_q;
    clrsel_e              clrsel_q;

    dacbank_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .valid_i     (cmd_valid_i),
        .op_i        (cmd_op_i),
        .addr_i      (cmd_addr_i),
        .ctl_o       (ctl),
        .ref_wr_o    (ref_wr),
        .clrsel_wr_o (clrsel_wr)
    );

    dacbank_clr_sync u_clr (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (clr_n_i),
        .fall_o  (clr_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= 1'b0;
            clrsel_q <= CS_ZERO;
        end else begin
            if (ref_wr) begin
                ref_q <= cmd_data_i[0];
            end
            if (clrsel_wr) begin
                clrsel_q <= clrsel_e'(cmd_data_i[1:0]);
            end
        end
    end

    always_comb begin
        case (clrsel_q)
            CS_MID:  clr_val = MID_CODE;
            CS_FULL: clr_val = FULL_CODE;
            default: clr_val = '0;
        endcase
    end

    assign clr_apply = clr_fall && (clrsel_q != CS_NONE);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dacbank_channel #(
            .CODE_W     (CODE_W),
            .RESET_CODE (RST_CODE)
        ) u_ch (
            .clk         (clk),
            .rst         (rst),
            .ctl_i       (ctl[g]),
            .data_i      (cmd_data_i),
            .pm_i        (cmd_data_i[1:0]),
            .mask_i      (cmd_data_i[0]),
            .ldac_low_i  (!ldac_n_i),
            .clr_apply_i (clr_apply),
            .clr_val_i   (clr_val),
            .code_o      (code_o[g*CODE_W +: CODE_W]),
            .pmode_o     (pmode_o[2*g +: 2]),
            .out_en_o    (out_en_o[g]),
            .mask_o      (ldac_mask_o[g])
        );
    end

    assign ref_en_o   = ref_q;
    assign clr_code_o = clrsel_q;

    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_wr |=> $stable(ref_en_o));

    // R8
    ref_write_chk: assert property (@(posedge clk) disable iff (rst)
        ref_wr |=> (ref_en_o == $past(cmd_data_i[0])));

    // R10
    clrsel_write_chk: assert property (@(posedge clk) disable iff (rst)
        clrsel_wr |=> (clr_code_o == $past(cmd_data_i[1:0])));

endmodule

// File: tb/test_dacbank_ctrl.sv
`timescale 1ns/1ps
module test_dacbank_ctrl;

    localparam int NCH = 8;
    localparam int CW  = 12;

    typedef struct {
        logic [NCH*CW-1:0] codes;
        logic [2*NCH-1:0]  pm;
        logic [NCH-1:0]    oe;
        logic              ref_en;
        logic [NCH-1:0]    mask;
        logic [1:0]        cc;
        string             req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [3:0] cmd_addr = '0;
    logic [CW-1:0] cmd_data = '0;
    logic ldac_n = 1'b1;
    logic clr_n = 1'b1;

    logic [NCH*CW-1:0] code_o, code_mid;
    logic [2*NCH-1:0]  pmode_o, pmode_mid;
    logic [NCH-1:0]    out_en_o, out_en_mid;
    logic              ref_en_o, ref_en_mid;
    logic [NCH-1:0]    mask_o, mask_mid;
    logic [1:0]        cc_o, cc_mid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t sb_q[$];

    // reference model
    logic [CW-1:0] m_in  [NCH];
    logic [CW-1:0] m_act [NCH];
    logic [1:0]    m_pm  [NCH];
    logic          m_mask[NCH];
    logic          m_ref;
    logic [1:0]    m_cc;
    logic          h1, h2, h3;

    always #5 clk = ~clk;

    dacbank_ctrl i_dacbank_ctrl (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .ldac_n_i(ldac_n),
        .clr_n_i(clr_n), .code_o(code_o), .pmode_o(pmode_o), .out_en_o(out_en_o),
        .ref_en_o(ref_en_o), .ldac_mask_o(mask_o), .clr_code_o(cc_o)
    );

    dacbank_ctrl #(.MID_RESET(1'b1)) i_dacbank_ctrl_mid (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .ldac_n_i(ldac_n),
        .clr_n_i(clr_n), .code_o(code_mid), .pmode_o(pmode_mid), .out_en_o(out_en_mid),
        .ref_en_o(ref_en_mid), .ldac_mask_o(mask_mid), .clr_code_o(cc_mid)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_in[i] = '0; m_act[i] = '0; m_pm[i] = 2'd0; m_mask[i] = 1'b0;
        end
        m_ref = 1'b0; m_cc = 2'd0;
        h1 = 1'b1; h2 = 1'b1; h3 = 1'b1;
    endtask

    task automatic push_exp(input string req);
        exp_t e;
        for (int i = 0; i < NCH; i++) begin
            e.codes[i*CW +: CW] = m_act[i];
            e.pm[2*i +: 2]      = m_pm[i];
            e.oe[i]             = (m_pm[i] == 2'd0);
            e.mask[i]           = m_mask[i];
        end
        e.ref_en = m_ref;
        e.cc     = m_cc;
        e.req    = req;
        sb_q.push_back(e);
    endtask

    task automatic model_edge(input logic v, input logic [3:0] op, input logic [3:0] addr,
                              input logic [CW-1:0] d, input logic ld_n, input logic cl_n);
        logic [CW-1:0] old_in [NCH];
        logic          old_mask [NCH];
        logic          wrote [NCH];
        logic          clr_now;
        logic [CW-1:0] cval;
        for (int i = 0; i < NCH; i++) begin
            old_in[i] = m_in[i]; old_mask[i] = m_mask[i]; wrote[i] = 1'b0;
        end
        clr_now = h3 && !h2 && (m_cc != 2'd3);
        h3 = h2; h2 = h1; h1 = cl_n;
        cval = (m_cc == 2'd1) ? 12'h800 : (m_cc == 2'd2) ? 12'hFFF : 12'h000;
        if (clr_now) begin
            for (int i = 0; i < NCH; i++) begin
                m_in[i] = cval; m_act[i] = cval;
            end
        end else begin
            if (v) begin
                for (int i = 0; i < NCH; i++) begin
                    logic hit;
                    hit = (addr == 4'(i)) || (addr == 4'hF);
                    case (op)
                        4'd0: if (hit) m_in[i] = d;
                        4'd1: if (hit) begin m_act[i] = old_in[i]; wrote[i] = 1'b1; end
                        4'd2: if (hit) begin m_in[i] = d; m_act[i] = d; wrote[i] = 1'b1; end
                        4'd3: begin
                            if (hit) begin m_in[i] = d; m_act[i] = d; end
                            else m_act[i] = old_in[i];
                            wrote[i] = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (!ld_n) begin
                for (int i = 0; i < NCH; i++) begin
                    if (!wrote[i] && !old_mask[i]) m_act[i] = old_in[i];
                end
            end
        end
        if (v) begin
            case (op)
                4'd4: if (addr < 4'd8) m_pm[addr[2:0]] = d[1:0];
                4'd5: m_ref = d[0];
                4'd6: if (addr < 4'd8) m_mask[addr[2:0]] = d[0];
                4'd7: m_cc = d[1:0];
                default: ;
            endcase
        end
    endtask

    // driver: one clock per call
    task automatic step(input logic v, input logic [3:0] op, input logic [3:0] addr,
                        input logic [CW-1:0] d, input logic ld_n, input logic cl_n,
                        input string req);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_addr = addr; cmd_data = d;
        ldac_n = ld_n; clr_n = cl_n;
        @(posedge clk);
        #1;
        model_edge(v, op, addr, d, ld_n, cl_n);
        push_exp(req);
    endtask

    task automatic cmd(input logic [3:0] op, input logic [3:0] addr,
                       input logic [CW-1:0] d, input string req);
        step(1'b1, op, addr, d, 1'b1, 1'b1, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 4'd0, 4'd0, '0, 1'b1, 1'b1, req);
    endtask

    task automatic clr_pulse(input string req);
        step(1'b0, 4'd0, 4'd0, '0, 1'b1, 1'b0, req);
        step(1'b0, 4'd0, 4'd0, '0, 1'b1, 1'b0, req);
        step(1'b0, 4'd0, 4'd0, '0, 1'b1, 1'b0, req);
        step(1'b0, 4'd0, 4'd0, '0, 1'b1, 1'b1, req);
    endtask

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, "codes", 128'(code_o), 128'(e.codes));
            check(e.req, "status",
                  128'({pmode_o, out_en_o, ref_en_o, mask_o, cc_o}),
                  128'({e.pm, e.oe, e.ref_en, e.mask, e.cc}));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of both variants
        push_exp("R1");
        @(negedge clk);
        check("R1", "midscale reset codes", 128'(code_mid), 128'({NCH{12'h800}}));
        check("R1", "midscale reset status",
              128'({pmode_mid, out_en_mid, ref_en_mid, mask_mid, cc_mid}),
              128'({16'h0, 8'hFF, 1'b0, 8'h00, 2'd0}));

        // R2: stage only
        cmd(4'd0, 4'd2, 12'hABC, "R2");
        idle("R2");
        // R3: commit
        cmd(4'd1, 4'd2, 12'h000, "R3");
        cmd(4'd0, 4'd5, 12'h123, "R2");
        cmd(4'd1, 4'd4, 12'h000, "R3");
        cmd(4'd1, 4'd5, 12'h000, "R3");
        // R4: broadcast and unused addresses
        cmd(4'd0, 4'hF, 12'h555, "R4");
        cmd(4'd1, 4'd9, 12'h000, "R4");
        cmd(4'd0, 4'd12, 12'hFFF, "R4");
        cmd(4'd2, 4'd14, 12'h777, "R4");
        cmd(4'd1, 4'hF, 12'h000, "R4");
        // R5: stage and commit, boundary codes
        cmd(4'd2, 4'd7, 12'hFFF, "R5");
        cmd(4'd2, 4'd0, 12'h000, "R5");
        cmd(4'd2, 4'hF, 12'h3C3, "R5");
        // R6: stage one, commit all
        cmd(4'd0, 4'd1, 12'h111, "R6");
        cmd(4'd0, 4'd3, 12'h333, "R6");
        cmd(4'd3, 4'd6, 12'h666, "R6");
        // R7: power modes keep codes
        cmd(4'd4, 4'd1, 12'h001, "R7");
        cmd(4'd4, 4'd3, 12'h003, "R7");
        cmd(4'd4, 4'd5, 12'h002, "R7");
        cmd(4'd2, 4'd3, 12'h7FF, "R7");
        cmd(4'd4, 4'd3, 12'h000, "R7");
        cmd(4'd4, 4'hF, 12'h003, "R7");
        // R8: reference enable
        cmd(4'd5, 4'd0, 12'h001, "R8");
        idle("R8");
        cmd(4'd0, 4'd0, 12'h000, "R8");
        cmd(4'd5, 4'd0, 12'h000, "R8");
        // R9: latch mask and pin
        cmd(4'd6, 4'd2, 12'h001, "R9");
        cmd(4'd6, 4'd4, 12'h001, "R9");
        cmd(4'd0, 4'hF, 12'h9A5, "R9");
        step(1'b0, 4'd0, 4'd0, 12'h000, 1'b0, 1'b1, "R9");
        idle("R9");
        cmd(4'd0, 4'd0, 12'h0AA, "R9");
        step(1'b1, 4'd0, 4'd0, 12'h0BB, 1'b0, 1'b1, "R9");
        step(1'b1, 4'd2, 4'd1, 12'h0CC, 1'b0, 1'b1, "R9");
        cmd(4'd6, 4'd2, 12'h000, "R9");
        step(1'b0, 4'd0, 4'd0, 12'h000, 1'b0, 1'b1, "R9");
        // R10: clear selector values
        cmd(4'd7, 4'd0, 12'h001, "R10");
        clr_pulse("R10");
        cmd(4'd0, 4'd3, 12'h456, "R10");
        cmd(4'd7, 4'd0, 12'h002, "R10");
        clr_pulse("R10");
        cmd(4'd2, 4'd5, 12'h0F0, "R10");
        cmd(4'd7, 4'd0, 12'h003, "R10");
        clr_pulse("R10");
        cmd(4'd7, 4'd0, 12'h000, "R10");
        clr_pulse("R10");
        // R11: command and latch on the clearing edge
        cmd(4'd0, 4'hF, 12'h321, "R11");
        cmd(4'd7, 4'd0, 12'h002, "R11");
        step(1'b0, 4'd0, 4'd0, 12'h000, 1'b1, 1'b0, "R11");
        step(1'b0, 4'd0, 4'd0, 12'h000, 1'b1, 1'b0, "R11");
        step(1'b1, 4'd2, 4'd1, 12'h001, 1'b0, 1'b0, "R11");
        step(1'b1, 4'd5, 4'd0, 12'h001, 1'b1, 1'b1, "R11");
        idle("R11");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule